// File: doc/BRIEF.md
# Retro Peripheral Bus Target Interface

This block sits on the device side of an 8-bit microcomputer expansion-slot bus and runs on a fast local system clock. The slot's three active-low select lines are ANDed outside the block into one select input. That input goes low whenever the host addresses the card. Each time the host opens a bus cycle, the block records the 12-bit address together with the read/write line as one word in an address FIFO. On a host write it waits a fixed settling time and then records the data byte in a write FIFO. On a host read it takes a byte from a read FIFO filled by the local side and drives that byte onto the data bus until the select input goes high again.

Three small sequencers do the work. The address sequencer has two states: `A_WAIT_HIGH` goes to `A_WAIT_LOW` when the synchronized select is high, and `A_WAIT_LOW` goes back to `A_WAIT_HIGH` when select is low. That second transition pushes the address word and, on a write, raises a write trigger. The capture sequencer goes from `W_IDLE` to `W_DELAY` when it takes the trigger. It returns from `W_DELAY` to `W_IDLE` after DELAY clocks, pushing the sampled byte on the way. The read driver goes from `R_WAIT_BYTE` to `R_DRIVE` when it pops a byte from the read FIFO, and from `R_DRIVE` back to `R_WAIT_BYTE` once select is high. All bus inputs pass through two-flop synchronizers. The local side uses valid/ready ports. Address decoding and the device behind the FIFOs belong to other blocks.

Top module: `retro_bus_target`

## Requirements
- R1: Under reset and directly after it, `bus_doe` is 0, `addr_valid` and `wr_valid` are 0, both overflow flags are 0 and `rd_ready` is 1.
- R2: A cycle is recognised only after select has been seen high and then low. A select that is already low when reset ends yields no address word until it has gone high once. One low period, however long, yields exactly one address word.
- R3: Every recognised cycle, read or write, pushes one 13-bit word into the address FIFO. Bits 11:0 hold the address and bit 12 holds the read/write line, where 1 means a host read.
- R4: A cycle with read/write = 1 adds no entry to the write FIFO.
- R5: A cycle with read/write = 0 adds exactly one byte to the write FIFO. The byte is the data bus value sampled DELAY (default 32) clocks after the cycle is recognised. A value placed on the bus 20 clocks after select falls is captured, and a value placed 40 clocks after is not. `wr_valid` is still 0 thirty clocks after select falls.
- R6: While the read FIFO is empty, `bus_doe` stays 0. Within 4 clocks of a byte entering the read FIFO, `bus_doe` is 1 and `bus_dout` carries that byte, with all 8 bits enabled together.
- R7: Once driving, `bus_doe` stays 1 while select stays low. It drops to 0 within 4 clocks after select goes high, and the driver then waits for the next byte.
- R8: The address FIFO and the write FIFO each hold 4 entries, delivered in order. A push into a full FIFO drops the new word, keeps the earlier entries, and sets the sticky flag `addr_ovf` or `wr_ovf`.
- R9: A one-clock pulse on `ovf_clr` returns both overflow flags to 0. If an overflow happens in the same clock as the pulse, the overflow wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Combined active-low slot select |
| bus_rw | input | 1 | Host read/write line, 1 = read |
| bus_addr | input | 12 | Host address lines |
| bus_din | input | 8 | Data bus as seen by the card |
| bus_dout | output | 8 | Data the card drives onto the bus |
| bus_doe | output | 1 | Active-high data bus output enable |
| addr_valid | output | 1 | Address FIFO holds a word |
| addr_ready | input | 1 | Local side takes the address word |
| addr_word | output | 13 | {read/write, address} of the oldest cycle |
| wr_valid | output | 1 | Write FIFO holds a byte |
| wr_ready | input | 1 | Local side takes the write byte |
| wr_byte | output | 8 | Oldest captured write byte |
| rd_valid | input | 1 | Local side offers a read byte |
| rd_ready | output | 1 | Read FIFO can accept a byte |
| rd_byte | input | 8 | Byte to return on the next host read |
| ovf_clr | input | 1 | Clears both overflow flags |
| addr_ovf | output | 1 | Sticky: an address word was dropped |
| wr_ovf | output | 1 | Sticky: a write byte was dropped |

## Verification
If the address sequencer sat in the wrong state, a cycle would be lost or doubled. That shows at `addr_valid` within three clocks of the select falling. A wrong capture counter moves the sampling point, so the byte placed on the bus 20 clocks in gives way to an older or newer value in `wr_byte` about 36 clocks after select falls. A read driver stuck in `R_DRIVE` or in `R_WAIT_BYTE` shows as a wrong `bus_doe` level within four clocks of a select rise or of a byte being offered.

// File: rtl/retro_bus_pkg.sv
package retro_bus_pkg;

    // Address sequencer: wait for select high, then wait for it to fall
    typedef enum logic [0:0] {
        A_WAIT_HIGH = 1'b0,
        A_WAIT_LOW  = 1'b1
    } addr_st_t;

    // Write-data capture sequencer
    typedef enum logic [0:0] {
        W_IDLE  = 1'b0,
        W_DELAY = 1'b1
    } wcap_st_t;

    // Read-data driver
    typedef enum logic [0:0] {
        R_WAIT_BYTE = 1'b0,
        R_DRIVE     = 1'b1
    } rd_st_t;

endpackage

// File: rtl/rbt_sync.sv
module rbt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rbt_fifo.sv
module rbt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wp, rp;
    logic         full, empty;

    assign full      = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
    assign empty     = (wp == rp);
    assign in_ready  = !full;
    assign out_valid = !empty;
    assign out_data  = mem[rp[PW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (in_valid && !full)
                wp <= wp + 1'b1;
            if (out_ready && !empty)
                rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && !full)
            mem[wp[PW-1:0]] <= in_data;
    end
endmodule

// File: rtl/rbt_addr_seq.sv
module rbt_addr_seq
    import retro_bus_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_s,
    input  logic        rw_s,
    input  logic [AW-1:0] addr_s,
    input  logic        trig_clr,
    output logic        push,
    output logic [AW:0] word,
    output logic        trig
);
    addr_st_t st, nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= A_WAIT_HIGH;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            A_WAIT_HIGH: if (sel_s)  nx = A_WAIT_LOW;
            A_WAIT_LOW:  if (!sel_s) nx = A_WAIT_HIGH;
        endcase
    end

    always_comb begin
        push = (st == A_WAIT_LOW) && !sel_s;
        word = {rw_s, addr_s};
    end

    // Write trigger: raised on a write cycle, consumed by the capture sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               trig <= 1'b0;
        else if (push && !rw_s)   trig <= 1'b1;
        else if (trig_clr)        trig <= 1'b0;
    end
endmodule

// File: rtl/rbt_wcap_seq.sv
module rbt_wcap_seq
    import retro_bus_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DELAY = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [DW-1:0] din_s,
    output logic          trig_clr,
    output logic          push,
    output logic [DW-1:0] data
);
    localparam int            CW   = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    wcap_st_t      st, nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            cnt <= '0;
        end else begin
            st  <= nx;
            cnt <= (st == W_IDLE) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        nx = st;
        unique case (st)
            W_IDLE:  if (trig)        nx = W_DELAY;
            W_DELAY: if (cnt == LAST) nx = W_IDLE;
        endcase
    end

    always_comb begin
        trig_clr = (st == W_IDLE) && trig;
        push     = (st == W_DELAY) && (cnt == LAST);
        data     = din_s;
    end
endmodule

// File: rtl/rbt_rd_drv.sv
module rbt_rd_drv
    import retro_bus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_s,
    input  logic          fifo_valid,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic [DW-1:0] dout,
    output logic          doe
);
    rd_st_t st, nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= R_WAIT_BYTE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            R_WAIT_BYTE: if (fifo_valid) nx = R_DRIVE;
            R_DRIVE:     if (sel_s)      nx = R_WAIT_BYTE;
        endcase
    end

    always_comb begin
        fifo_pop = (st == R_WAIT_BYTE) && fifo_valid;
        doe      = (st == R_DRIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dout <= '0;
        else if (fifo_pop) dout <= fifo_data;
    end
endmodule

// File: rtl/retro_bus_target.sv
module retro_bus_target #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int DELAY      = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W:0]   addr_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [DATA_W-1:0] wr_byte,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              ovf_clr,
    output logic              addr_ovf,
    output logic              wr_ovf
);
    localparam int SW = 2 + ADDR_W + DATA_W;

    logic              sel_s, rw_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;

    logic              apush, af_in_ready;
    logic [ADDR_W:0]   aword;
    logic              wr_trig, trig_clr;
    logic              wpush, wf_in_ready;
    logic [DATA_W-1:0] wdata;
    logic              rf_valid, rd_pop;
    logic [DATA_W-1:0] rf_data;

    rbt_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_sel_n, bus_rw, bus_addr, bus_din}),
        .q     ({sel_s, rw_s, addr_s, din_s})
    );

    rbt_addr_seq #(.AW(ADDR_W)) u_addr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .rw_s     (rw_s),
        .addr_s   (addr_s),
        .trig_clr (trig_clr),
        .push     (apush),
        .word     (aword),
        .trig     (wr_trig)
    );

    rbt_wcap_seq #(.DW(DATA_W), .DELAY(DELAY)) u_wcap_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (wr_trig),
        .din_s    (din_s),
        .trig_clr (trig_clr),
        .push     (wpush),
        .data     (wdata)
    );

    rbt_rd_drv #(.DW(DATA_W)) u_rd_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (sel_s),
        .fifo_valid (rf_valid),
        .fifo_data  (rf_data),
        .fifo_pop   (rd_pop),
        .dout       (bus_dout),
        .doe        (bus_doe)
    );

    rbt_fifo #(.W(ADDR_W + 1), .DEPTH(FIFO_DEPTH)) u_addr_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (apush),
        .in_ready  (af_in_ready),
        .in_data   (aword),
        .out_valid (addr_valid),
        .out_ready (addr_ready),
        .out_data  (addr_word)
    );

    rbt_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_wr_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (wpush),
        .in_ready  (wf_in_ready),
        .in_data   (wdata),
        .out_valid (wr_valid),
        .out_ready (wr_ready),
        .out_data  (wr_byte)
    );

    rbt_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rd_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_valid),
        .in_ready  (rd_ready),
        .in_data   (rd_byte),
        .out_valid (rf_valid),
        .out_ready (rd_pop),
        .out_data  (rf_data)
    );

    // Sticky drop flags; a drop in the same clock as a clear keeps the flag set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_ovf <= 1'b0;
            wr_ovf   <= 1'b0;
        end else begin
            if (apush && !af_in_ready) addr_ovf <= 1'b1;
            else if (ovf_clr)          addr_ovf <= 1'b0;
            if (wpush && !wf_in_ready) wr_ovf <= 1'b1;
            else if (ovf_clr)          wr_ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/retro_bus_target_chk.sv
module retro_bus_target_chk #(
    parameter int AW    = 12,
    parameter int DELAY = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_s,
    input logic        apush,
    input logic [AW:0] aword,
    input logic        af_in_ready,
    input logic        addr_ovf,
    input logic        wr_trig,
    input logic        trig_clr,
    input logic        wpush,
    input logic        wf_in_ready,
    input logic        wr_ovf,
    input logic        doe
);
    int unsigned since_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         since_clr <= 32'hFFFF_FFFF;
        else if (trig_clr)                  since_clr <= 0;
        else if (since_clr != 32'hFFFF_FFFF) since_clr <= since_clr + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) assert_doe_off_in_reset_R1: assert (!doe);
    end

    assert_push_only_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        apush |-> !sel_s);

    assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        apush |=> !apush);

    assert_read_no_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (apush && aword[AW]) |=> !$rose(wr_trig));

    assert_capture_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wpush |-> (since_clr == DELAY - 1));

    assert_release_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && sel_s) |=> !doe);

    assert_addr_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_ovf) |-> $past(!af_in_ready));

    assert_wr_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ovf) |-> $past(!wf_in_ready));
endmodule

bind retro_bus_target retro_bus_target_chk #(.AW(ADDR_W), .DELAY(DELAY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (sel_s),
    .apush       (apush),
    .aword       (aword),
    .af_in_ready (af_in_ready),
    .addr_ovf    (addr_ovf),
    .wr_trig     (wr_trig),
    .trig_clr    (trig_clr),
    .wpush       (wpush),
    .wf_in_ready (wf_in_ready),
    .wr_ovf      (wr_ovf),
    .doe         (bus_doe)
);

// File: tb/retro_bus_target_tb.sv
module retro_bus_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_n = 1'b0;
    logic        bus_rw = 1'b1;
    logic [11:0] bus_addr = 12'h0AB;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [12:0] addr_word;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [7:0]  wr_byte;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [7:0]  rd_byte = 8'h00;
    logic        ovf_clr = 1'b0;
    logic        addr_ovf;
    logic        wr_ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    retro_bus_target u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_word(addr_word),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
        .ovf_clr(ovf_clr), .addr_ovf(addr_ovf), .wr_ovf(wr_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [11:0] a, input logic rw, input logic [7:0] d_mid,
                             input int low_len);
        bus_addr = a;
        bus_rw = rw;
        bus_sel_n = 1'b1;
        tick(4);
        bus_sel_n = 1'b0;
        bus_din = ~d_mid;
        tick(20);
        bus_din = d_mid;
        tick(20);
        bus_din = d_mid ^ 8'h5A;
        tick(low_len - 40);
        bus_sel_n = 1'b1;
        tick(6);
    endtask

    task automatic pop_addr(input string req, input logic [12:0] exp);
        check(req, 32'(addr_valid), 32'd1);
        check(req, 32'(addr_word), 32'(exp));
        addr_ready = 1'b1;
        tick(1);
        addr_ready = 1'b0;
    endtask

    task automatic pop_wr(input string req, input logic [7:0] exp);
        check(req, 32'(wr_valid), 32'd1);
        check(req, 32'(wr_byte), 32'(exp));
        wr_ready = 1'b1;
        tick(1);
        wr_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] a;
        logic [7:0]  b;
        tick(5);
        // R1: reset state
        check("R1 doe", 32'(bus_doe), 0);
        check("R1 addr_valid", 32'(addr_valid), 0);
        check("R1 wr_valid", 32'(wr_valid), 0);
        check("R1 ovf", 32'({addr_ovf, wr_ovf}), 0);
        check("R1 rd_ready", 32'(rd_ready), 1);
        rst_n = 1'b1;
        tick(20);
        // R2: select low since reset gives nothing
        check("R2 no start while low", 32'(addr_valid), 0);
        // R2: one long low period gives one word
        bus_sel_n = 1'b1;
        tick(4);
        bus_sel_n = 1'b0;
        tick(100);
        bus_sel_n = 1'b1;
        tick(4);
        pop_addr("R2 single word", {1'b1, 12'h0AB});
        check("R2 no second word", 32'(addr_valid), 0);

        // R5: capture timing window
        bus_addr = 12'h321;
        bus_rw = 1'b0;
        tick(4);
        bus_sel_n = 1'b0;
        bus_din = 8'h11;
        tick(20);
        bus_din = 8'h22;
        tick(10);
        check("R5 not before delay", 32'(wr_valid), 0);
        tick(10);
        bus_din = 8'h33;
        tick(5);
        check("R5 after delay", 32'(wr_valid), 1);
        bus_sel_n = 1'b1;
        tick(6);
        pop_wr("R5 mid value", 8'h22);
        check("R5 one byte", 32'(wr_valid), 0);
        pop_addr("R3 write word", {1'b0, 12'h321});

        // R3/R4/R5: sweep of addresses and directions
        for (int i = 0; i < 14; i++) begin
            for (int rw = 0; rw < 2; rw++) begin
                a = (i < 12) ? 12'(1 << i) : ((i == 12) ? 12'h000 : 12'hFFF);
                b = 8'(i * 29 + rw * 7 + 3);
                bus_cycle(a, rw[0], b, 50);
                pop_addr("R3 sweep word", {rw[0], a});
                if (rw == 0) pop_wr("R5 sweep byte", b);
                else         check("R4 read adds no byte", 32'(wr_valid), 0);
            end
        end

        // R6/R7: read drive sweep
        for (int k = 0; k < 10; k++) begin
            b = (k < 8) ? 8'(1 << k) : ((k == 8) ? 8'h00 : 8'hFF);
            bus_addr = 12'(k);
            bus_rw = 1'b1;
            bus_sel_n = 1'b1;
            tick(4);
            bus_sel_n = 1'b0;
            tick(10);
            check("R6 idle while empty", 32'(bus_doe), 0);
            rd_byte = b;
            rd_valid = 1'b1;
            tick(1);
            rd_valid = 1'b0;
            tick(4);
            check("R6 drive on", 32'(bus_doe), 1);
            check("R6 drive byte", 32'(bus_dout), 32'(b));
            tick(20);
            check("R7 held while low", 32'(bus_doe), 1);
            bus_sel_n = 1'b1;
            tick(1);
            check("R7 held until high seen", 32'(bus_doe), 1);
            tick(4);
            check("R7 released", 32'(bus_doe), 0);
            pop_addr("R3 read word", {1'b1, 12'(k)});
        end

        // R8: overflow of both FIFOs
        for (int j = 0; j < 5; j++)
            bus_cycle(12'(12'h100 + j), 1'b0, 8'(8'h40 + j), 50);
        check("R8 addr_ovf set", 32'(addr_ovf), 1);
        check("R8 wr_ovf set", 32'(wr_ovf), 1);
        for (int j = 0; j < 4; j++) pop_addr("R8 addr kept", {1'b0, 12'(12'h100 + j)});
        check("R8 addr fifth dropped", 32'(addr_valid), 0);
        for (int j = 0; j < 4; j++) pop_wr("R8 wr kept", 8'(8'h40 + j));
        check("R8 wr fifth dropped", 32'(wr_valid), 0);

        // R9: clear
        ovf_clr = 1'b1;
        tick(1);
        ovf_clr = 1'b0;
        check("R9 cleared", 32'({addr_ovf, wr_ovf}), 0);
        bus_cycle(12'h7E7, 1'b0, 8'h9C, 50);
        check("R9 stays clear", 32'({addr_ovf, wr_ovf}), 0);
        pop_addr("R9 word", {1'b0, 12'h7E7});
        pop_wr("R9 byte", 8'h9C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule